// File: doc/BRIEF.md
# DRAM Connectivity Test-Mode Controller

This block sits on the device side of a synchronous DRAM and decides whether the part is in a low-level pin connectivity test mode. The test mode is used before the external clock runs, so the block samples the command pins (CKE, CS#, RAS#, CAS#, WE#) with a free-running internal reference clock. It looks for edges on the sampled CAS# to enter and leave the mode.

While the mode is active and the pins request it, the DQ drivers are enabled. DQ then carries a fixed placeholder function of the address and bank pins, so a tester can confirm that each pin is connected. The mode is optional. The first precharge command permanently disarms it, and only a power-on reset arms it again.

All command pins, address and bank are registered once by the reference clock. The mode state is a second register stage. A pin change that happens before clock edge k therefore shows up in the mode state after edge k+1. It shows up in the pin-qualified output enable after edge k.

Top module: `dram_conn_test_ctrl`

## Requirements
- R1: While rst_ni is low and after it is released, with no further stimulus, test_mode_o, dq_oe_o and lockout_o are 0 and dq_o is all zeros.
- R2: A falling edge of the sampled CAS# (1 at edge k-1, 0 at edge k) while the sampled CS# and CKE are both 0 at edge k, with the block armed, sets test_mode_o to 1 after edge k+1.
- R3: In test mode, a rising edge of the sampled CAS# at edge k clears test_mode_o after edge k+1. A later qualifying falling edge re-enters the mode as long as no precharge has been seen.
- R4: dq_oe_o is 1 exactly when test_mode_o is 1 and the pins sampled at the last edge show CS#=0, CKE=0, WE#=1 and CAS#=0. A CAS# rise, CS# high or CKE high at the last edge therefore forces it to 0.
- R5: A precharge command (CKE=1, CS#=0, RAS#=0, CAS#=1, WE#=0) sampled at edge k sets lockout_o after edge k+1 and forces test_mode_o to 0. lockout_o then stays 1 until rst_ni is asserted.
- R6: While lockout_o is 1, no CAS# falling edge sets test_mode_o, whatever the other pins are.
- R7: When dq_oe_o is 1, bit i of dq_o equals bit (i mod 13) of the 13-bit word {bank, addr} sampled at the last edge, where addr occupies the low 11 bits. When dq_oe_o is 0, dq_o is all zeros.
- R8: A CAS# falling edge leaves test_mode_o at 0 if the sampled CS# or CKE is 1 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running internal reference clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| cke_i | input | 1 | Clock-enable pin |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 11 | Address pins |
| bank_i | input | 2 | Bank select pins |
| test_mode_o | output | 1 | Connectivity test mode active |
| dq_oe_o | output | 1 | Output enable for the DQ drivers |
| dq_o | output | 32 | Data pins driven in test mode |
| lockout_o | output | 1 | Test mode permanently disarmed |

## Verification
Directed sequences first separate a qualified CAS# fall from falls with CS# high or CKE high. Next they separate the exit rise from a following re-entry, and a precharge sent in the armed state from one sent inside the test mode. Walking and alternating address and bank patterns expose any swapped or stuck DQ replication bit. Constrained random cycles then mix CAS# toggling with random WE#, CS#, CKE and rare precharges, with periodic resets. This shows whether the output enable, lockout and mode flag track the pin history correctly, including when entry, exit and lockout events coincide.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_TEST   = 2'd1,
    ST_LOCKED = 2'd2
  } mode_e;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
endpackage

// File: rtl/dct_sample.sv
module dct_sample
  import dct_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  output ctl_t              ctl_q_o,
  output logic              cas_prev_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [BANK_W-1:0] bank_q_o
);
  ctl_t              ctl_q;
  logic              cas_prev_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= CTL_IDLE;
      cas_prev_q <= 1'b1;
      addr_q     <= '0;
      bank_q     <= '0;
    end else begin
      ctl_q      <= ctl_i;
      cas_prev_q <= ctl_q.cas_n;
      addr_q     <= addr_i;
      bank_q     <= bank_i;
    end
  end

  assign ctl_q_o    = ctl_q;
  assign cas_prev_o = cas_prev_q;
  assign addr_q_o   = addr_q;
  assign bank_q_o   = bank_q;
endmodule

// File: rtl/dct_decode.sv
module dct_decode
  import dct_pkg::*;
(
  input  ctl_t ctl_q_i,
  input  logic cas_prev_i,
  output logic cas_fall_o,
  output logic cas_rise_o,
  output logic entry_ok_o,
  output logic pre_cmd_o,
  output logic pins_drive_o
);
  always_comb begin
    cas_fall_o   = cas_prev_i & ~ctl_q_i.cas_n;
    cas_rise_o   = ~cas_prev_i & ctl_q_i.cas_n;
    entry_ok_o   = cas_fall_o & ~ctl_q_i.cs_n & ~ctl_q_i.cke;
    pre_cmd_o    = ctl_q_i.cke & ~ctl_q_i.cs_n & ~ctl_q_i.ras_n & ctl_q_i.cas_n & ~ctl_q_i.we_n;
    pins_drive_o = ~ctl_q_i.cs_n & ~ctl_q_i.cke & ctl_q_i.we_n & ~ctl_q_i.cas_n;
  end
endmodule

// File: rtl/dct_mode_fsm.sv
module dct_mode_fsm
  import dct_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic entry_ok_i,
  input  logic cas_fall_i,
  input  logic cas_rise_i,
  input  logic pre_cmd_i,
  output logic test_mode_o,
  output logic lockout_o
);
  mode_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARMED: begin
        if (pre_cmd_i)       state_d = ST_LOCKED;
        else if (entry_ok_i) state_d = ST_TEST;
      end
      ST_TEST: begin
        if (pre_cmd_i)       state_d = ST_LOCKED;
        else if (cas_rise_i) state_d = ST_ARMED;
      end
      ST_LOCKED: state_d = ST_LOCKED;
      default:   state_d = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ARMED;
    else         state_q <= state_d;
  end

  assign test_mode_o = (state_q == ST_TEST);
  assign lockout_o   = (state_q == ST_LOCKED);

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_o |=> lockout_o); // R5
  AST_PRE_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_cmd_i |=> (lockout_o && !test_mode_o)); // R5
  AST_NO_ENTRY_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lockout_o && cas_fall_i) |=> !test_mode_o); // R6
  AST_EXIT_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_mode_o && cas_rise_i) |=> !test_mode_o); // R3
  AST_ENTRY_NEEDS_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_mode_o && !cas_fall_i) |=> !test_mode_o); // R2
endmodule

// File: rtl/dct_pattern.sv
module dct_pattern #(
  parameter int ADDR_W = 11,
  parameter int BANK_W = 2,
  parameter int DQ_W   = 32
) (
  input  logic              oe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [DQ_W-1:0]   dq_o
);
  localparam int PW = ADDR_W + BANK_W;

  logic [PW-1:0] pat;
  assign pat = {bank_i, addr_i};

  for (genvar i = 0; i < DQ_W; i++) begin : g_dq
    assign dq_o[i] = oe_i & pat[i % PW];
  end
endmodule

// File: rtl/dram_conn_test_ctrl.sv
module dram_conn_test_ctrl
  import dct_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BANK_W = 2,
  parameter int DQ_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              test_mode_o,
  output logic              dq_oe_o,
  output logic [DQ_W-1:0]   dq_o,
  output logic              lockout_o
);
  ctl_t              ctl_in, ctl_q;
  logic              cas_prev;
  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;
  logic              cas_fall, cas_rise, entry_ok, pre_cmd, pins_drive;

  assign ctl_in = '{cke: cke_i, cs_n: cs_ni, ras_n: ras_ni, cas_n: cas_ni, we_n: we_ni};

  dct_sample #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_sample (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_i      (ctl_in),
    .addr_i     (addr_i),
    .bank_i     (bank_i),
    .ctl_q_o    (ctl_q),
    .cas_prev_o (cas_prev),
    .addr_q_o   (addr_q),
    .bank_q_o   (bank_q)
  );

  dct_decode u_decode (
    .ctl_q_i      (ctl_q),
    .cas_prev_i   (cas_prev),
    .cas_fall_o   (cas_fall),
    .cas_rise_o   (cas_rise),
    .entry_ok_o   (entry_ok),
    .pre_cmd_o    (pre_cmd),
    .pins_drive_o (pins_drive)
  );

  dct_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .entry_ok_i  (entry_ok),
    .cas_fall_i  (cas_fall),
    .cas_rise_i  (cas_rise),
    .pre_cmd_i   (pre_cmd),
    .test_mode_o (test_mode_o),
    .lockout_o   (lockout_o)
  );

  // enable is gated by CAS# low, so the exit cycle never drives
  assign dq_oe_o = test_mode_o & pins_drive;

  dct_pattern #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .DQ_W(DQ_W)) u_pattern (
    .oe_i   (dq_oe_o),
    .addr_i (addr_q),
    .bank_i (bank_q),
    .dq_o   (dq_o)
  );

  AST_OE_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (test_mode_o && !lockout_o)); // R4
  AST_OE_OFF_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_rise |-> !dq_oe_o); // R4
  AST_DQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> (dq_o == '0)); // R7
  AST_MODE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({test_mode_o, lockout_o})); // R5
endmodule

// File: tb/dram_conn_test_ctrl_test.sv
`timescale 1ns/1ps
module dram_conn_test_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [10:0] addr = '0;
  logic [1:0]  bank = '0;
  logic        test_mode, dq_oe, lockout;
  logic [31:0] dq;

  int checks = 0;
  int failures = 0;

  // model: 0 armed, 1 test, 2 locked
  int          m_state;
  logic        m_cke, m_cs, m_ras, m_cas, m_we, m_prev;
  logic [10:0] m_addr;
  logic [1:0]  m_bank;

  always #5 clk = ~clk;

  dram_conn_test_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .addr_i(addr), .bank_i(bank),
    .test_mode_o(test_mode), .dq_oe_o(dq_oe), .dq_o(dq), .lockout_o(lockout)
  );

  function automatic logic [31:0] exp_dq(logic oe, logic [10:0] a, logic [1:0] b);
    logic [12:0] p;
    logic [31:0] r;
    p = {b, a};
    for (int i = 0; i < 32; i++) r[i] = oe & p[i % 13];
    return r;
  endfunction

  function automatic logic exp_oe();
    return (m_state == 1) && !m_cs && !m_cke && m_we && !m_cas;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_state = 0;
    m_cke = 1'b0; m_cs = 1'b1; m_ras = 1'b1; m_cas = 1'b1; m_we = 1'b1;
    m_prev = 1'b1; m_addr = '0; m_bank = '0;
  endtask

  task automatic model_edge();
    logic fall, rise, pre;
    fall = m_prev & ~m_cas;
    rise = ~m_prev & m_cas;
    pre  = m_cke & ~m_cs & ~m_ras & m_cas & ~m_we;
    if (m_state != 2 && pre)                        m_state = 2;
    else if (m_state == 0 && fall && !m_cs && !m_cke) m_state = 1;
    else if (m_state == 1 && rise)                  m_state = 0;
    m_prev = m_cas;
    m_cke = cke; m_cs = cs_n; m_ras = ras_n; m_cas = cas_n; m_we = we_n;
    m_addr = addr; m_bank = bank;
  endtask

  task automatic compare_all();
    logic oe;
    oe = exp_oe();
    chk("R2/R3 test_mode", {31'd0, test_mode}, {31'd0, m_state == 1});
    chk("R5 lockout", {31'd0, lockout}, {31'd0, m_state == 2});
    chk("R4 dq_oe", {31'd0, dq_oe}, {31'd0, oe});
    chk("R7 dq", dq, exp_dq(oe, m_addr, m_bank));
  endtask

  // one reference-clock edge; inputs were set at the previous negedge
  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic set_pins(logic k, logic c, logic r, logic ca, logic w);
    cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    set_pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    addr = '0; bank = '0;
    #20;
    model_reset();
    chk("R1 reset test_mode", {31'd0, test_mode}, 32'd0);
    chk("R1 reset dq_oe", {31'd0, dq_oe}, 32'd0);
    chk("R1 reset lockout", {31'd0, lockout}, 32'd0);
    chk("R1 reset dq", dq, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic enter_test();
    set_pins(1'b0, 1'b0, 1'b1, 1'b1, 1'b1); tick();
    set_pins(1'b0, 1'b0, 1'b1, 1'b0, 1'b1); tick(); tick();
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();
    tick(); tick();
    chk("R1 idle test_mode", {31'd0, test_mode}, 32'd0);

    // R8: fall with CS# high, then with CKE high
    set_pins(1'b0, 1'b1, 1'b1, 1'b0, 1'b1); tick(); tick();
    chk("R8 cs high blocks entry", {31'd0, test_mode}, 32'd0);
    set_pins(1'b1, 1'b0, 1'b1, 1'b1, 1'b1); tick();
    set_pins(1'b1, 1'b0, 1'b1, 1'b0, 1'b1); tick(); tick();
    chk("R8 cke high blocks entry", {31'd0, test_mode}, 32'd0);

    // R2 entry and R7 patterns
    enter_test();
    chk("R2 entered", {31'd0, test_mode}, 32'd1);
    for (int i = 0; i < 13; i++) begin
      {bank, addr} = 13'd1 << i; tick();
      chk("R7 walking one", dq, exp_dq(1'b1, addr, bank));
    end
    {bank, addr} = 13'h0AAA; tick();
    chk("R7 alternating", dq, {dq[18:13] == 6'b0 ? 32'h0 : 32'h0} | exp_dq(1'b1, addr, bank));
    // R4: WE# low turns the drivers off
    we_n = 1'b0; tick();
    chk("R4 we low no drive", {31'd0, dq_oe}, 32'd0);
    we_n = 1'b1; tick();
    chk("R4 drive restored", {31'd0, dq_oe}, 32'd1);

    // R3 exit and re-entry
    cas_n = 1'b1; tick();
    chk("R4 off at exit edge", {31'd0, dq_oe}, 32'd0);
    tick();
    chk("R3 exited", {31'd0, test_mode}, 32'd0);
    cas_n = 1'b0; tick(); tick();
    chk("R3 re-entered", {31'd0, test_mode}, 32'd1);

    // R5 precharge inside test mode, then R6 no re-entry
    set_pins(1'b1, 1'b0, 1'b0, 1'b1, 1'b0); tick(); tick();
    chk("R5 lock from test", {31'd0, lockout}, 32'd1);
    chk("R5 mode cleared", {31'd0, test_mode}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      set_pins(1'b0, 1'b0, 1'b1, 1'b1, 1'b1); tick();
      set_pins(1'b0, 1'b0, 1'b1, 1'b0, 1'b1); tick(); tick();
      chk("R6 locked no entry", {31'd0, test_mode}, 32'd0);
    end
    chk("R5 lock persists", {31'd0, lockout}, 32'd1);

    // R5 precharge from armed; reset clears
    do_reset();
    set_pins(1'b1, 1'b0, 1'b0, 1'b1, 1'b0); tick(); tick();
    chk("R5 lock from armed", {31'd0, lockout}, 32'd1);
    do_reset();
    tick();
    chk("R1 reset clears lock", {31'd0, lockout}, 32'd0);

    // constrained random, mixed with periodic resets
    for (int n = 0; n < 4000; n++) begin
      if (n % 400 == 399) do_reset();
      cke   = ($urandom_range(0, 9) < 2);
      cs_n  = ($urandom_range(0, 9) < 2);
      we_n  = ($urandom_range(0, 9) < 7);
      ras_n = ($urandom_range(0, 99) >= 3);
      if ($urandom_range(0, 9) < 3) cas_n = ~cas_n;
      addr  = 11'($urandom);
      bank  = 2'($urandom);
      tick();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule